// File: doc/BRIEF.md
# Banked I2C Serial Memory Slave

This block is an I2C target that fronts three independent banks of byte storage, each 256 locations deep. A controller on the bus picks a bank with two bits of the 7-bit target address, sets a word pointer, and then writes one byte or a burst of up to one page, or reads one or many bytes. The storage is a register array clocked by the system clock. A programmable busy window after each completed write stands in for the programming time of a nonvolatile cell.

The bus lines arrive as plain inputs and are oversampled by the system clock. SDA is driven open-drain: `sda_oe` high means "pull the line low". A write-protect input blocks every write through this port. A single word pointer is shared by all banks and follows the usual serial-memory rules for current-address reads. The pointer always wraps inside the bank that is currently selected.

Top module: `eeprom_bank_slave`

## Requirements
- R1: After reset `sda_oe` is low and every location of every bank reads back as 8'hFF.
- R2: The target answers (acknowledges) only the address byte {4'b1010, 1'b0, bank[1:0], rw}, with bank 0 to 2 and rw=1 meaning read. Any other upper pattern, and bank value 3, gets no acknowledge. `sda_oe` changes only while SCL is low.
- R3: A write of a word address followed by one data byte stores that byte, and a later random read of that address returns it.
- R4: A write burst of up to 8 data bytes stores them at consecutive addresses starting at the word address.
- R5: In a burst, the low 3 address bits wrap inside the 8-byte page, so bytes past the page end overwrite earlier locations of the same page. Other pages are left unchanged.
- R6: In a read, each acknowledge from the controller after bit D0 advances the pointer and continues with the next byte. Going past address 8'hFF continues at address 8'h00 of the same bank.
- R7: A current-address read that follows a read returns the byte one past the last byte transferred.
- R8: A current-address read that follows a write returns the byte at the most recently written address.
- R9: The banks are independent: a write to one bank leaves the same address in every other bank unchanged.
- R10: While `wp_i` is high, data bytes get no acknowledge, the memory is unchanged, and no busy window starts.
- R11: After a stop that ends a write that stored at least one byte, the target ignores its address for BUSY_CYCLES clocks and acknowledges it again afterwards.
- R12: After the controller answers a read byte with no acknowledge, the target releases SDA and does not drive it again until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| wp_i | input | 1 | Write protect, high blocks writes |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
A corrupted pointer shows up on the very next byte read back: random, current and sequential reads return the wrong location, and a wrap error in bank or page shows as a stale 8'hFF or a wrong overwrite once the bytes are read back in order. A control state that is off by one bit shows within one byte time as a missing or extra acknowledge, or as SDA being driven during a bit the controller owns. A wrong busy counter is seen as an acknowledge inside the window, or a refusal after it, on the first address byte sent.

// File: rtl/eeprom_bank_pkg.sv
// Package: shared types for the banked I2C serial memory slave.
// Assumes: the protocol engine is the only user of the state encoding.
package eeprom_bank_pkg;

    // Fixed upper part of the target address {1010, 0}
    localparam logic [4:0] DEV_ID = 5'b10100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WORD,
        ST_ACK_WORD,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_RDATA,
        ST_RACK
    } proto_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain through a STAGES-deep synchronizer
// and produces one-cycle pulses for SCL edges and for start and stop conditions.
// Assumes: STAGES >= 2 and bus phases last several system clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    // Synchronizer chains plus one delayed copy; bus idle (high) at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_s     = scl_q[STAGES-1];
        sda_s     = sda_q[STAGES-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/bank_store.sv
// Module: bank_store
// Holds NUM_BANKS banks of WORDS bytes each, one write port and one
// asynchronous read port, all bytes set to 8'hFF by reset.
// Assumes: NUM_BANKS <= 4 (two-bit bank select).
module bank_store #(
    parameter int NUM_BANKS = 3,
    parameter int WORDS     = 256,
    localparam int AW       = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    wbank,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [1:0]    rbank,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] bank_rd [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [7:0] cells [WORDS];

        // One bank: erase to FFh on reset, write when selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WORDS; i++) cells[i] <= 8'hFF;
            end else if (we && (wbank == 2'(g))) begin
                cells[waddr] <= wdata;
            end
        end

        assign bank_rd[g] = cells[raddr];
    end

    // Read mux across banks; an absent bank reads as erased
    always_comb begin
        rdata = 8'hFF;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rbank == 2'(b)) rdata = bank_rd[b];
        end
    end

endmodule

// File: rtl/write_busy_timer.sv
// Module: write_busy_timer
// Models the programming time of a write: a load pulse starts a window of
// BUSY_CYCLES clocks during which busy is high.
// Assumes: BUSY_CYCLES >= 1.
module write_busy_timer #(
    parameter int BUSY_CYCLES = 300,
    localparam int CW         = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    logic [CW-1:0] cnt;

    // Load on a completed write, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CW'(BUSY_CYCLES);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);

    AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (cnt == $past(cnt) - CW'(1)));                      // R11

endmodule

// File: rtl/i2c_proto_fsm.sv
// Module: i2c_proto_fsm
// Bit-level I2C target engine: decodes the address byte, loads the word
// pointer, stores write data with page wrap, and shifts read data out.
// Samples SDA on SCL rise, changes its SDA drive only after an SCL fall.
// Assumes: event pulses come from i2c_line_sync; read data is combinational.
module i2c_proto_fsm
    import eeprom_bank_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    parameter int WORDS      = 256,
    parameter int PAGE_BYTES = 8,
    localparam int AW        = $clog2(WORDS),
    localparam int PW        = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          wp_i,
    input  logic          busy_i,
    input  logic [7:0]    rdata,
    output logic          sda_oe,
    output logic          mem_we,
    output logic [1:0]    mem_bank,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic          wr_done
);

    localparam logic [1:0] LAST_BANK = 2'(NUM_BANKS - 1);

    proto_state_t  state;
    logic [3:0]    cnt;
    logic [7:0]    sh;
    logic [7:0]    tx;
    logic          rw;
    logic [1:0]    bank;
    logic [AW-1:0] ptr;
    logic [AW-1:0] wptr;
    logic          wrote;
    logic          more;
    logic          oe_q;
    logic          byte_end;

    // Byte boundary: eight bits taken, clock just went low
    assign byte_end  = scl_fall && (cnt == 4'd8);
    assign mem_we    = (state == ST_WDATA) && byte_end && !wp_i;
    assign mem_bank  = bank;
    assign mem_waddr = wptr;
    assign mem_wdata = sh;
    assign mem_raddr = ptr;
    assign wr_done   = stop_det && wrote;
    assign sda_oe    = oe_q;

    // Protocol sequencing, shift registers, pointers and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
            tx    <= '0;
            rw    <= 1'b0;
            bank  <= '0;
            ptr   <= '0;
            wptr  <= '0;
            wrote <= 1'b0;
            more  <= 1'b0;
            oe_q  <= 1'b0;
        end else if (start_det) begin
            oe_q  <= 1'b0;
            cnt   <= '0;
            state <= busy_i ? ST_IDLE : ST_ADDR;
        end else if (stop_det) begin
            oe_q  <= 1'b0;
            wrote <= 1'b0;
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (byte_end) begin
                        if (sh[7:3] == DEV_ID && sh[2:1] <= LAST_BANK) begin
                            bank  <= sh[2:1];
                            rw    <= sh[0];
                            oe_q  <= 1'b1;
                            state <= ST_ACK_ADDR;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx    <= rdata;
                            oe_q  <= ~rdata[7];
                            state <= ST_RDATA;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_WORD;
                        end
                    end
                end
                ST_WORD: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (byte_end) begin
                        ptr   <= sh[AW-1:0];
                        wptr  <= sh[AW-1:0];
                        oe_q  <= 1'b1;
                        state <= ST_ACK_WORD;
                    end
                end
                ST_ACK_WORD, ST_ACK_WDATA: begin
                    if (scl_fall) begin
                        oe_q  <= 1'b0;
                        cnt   <= '0;
                        state <= ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (byte_end) begin
                        if (wp_i) begin
                            state <= ST_IDLE;
                        end else begin
                            ptr   <= wptr;
                            wptr  <= {wptr[AW-1:PW], wptr[PW-1:0] + PW'(1)};
                            wrote <= 1'b1;
                            oe_q  <= 1'b1;
                            state <= ST_ACK_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        tx  <= {tx[6:0], 1'b0};
                        cnt <= cnt + 4'd1;
                    end else if (byte_end) begin
                        oe_q  <= 1'b0;
                        ptr   <= ptr + AW'(1);
                        state <= ST_RACK;
                    end else if (scl_fall) begin
                        oe_q <= ~tx[7];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        more <= ~sda_s;
                    end else if (scl_fall) begin
                        if (more) begin
                            tx    <= rdata;
                            oe_q  <= ~rdata[7];
                            cnt   <= '0;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> !scl_s);                                             // R2
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !oe_q);                                          // R12
    AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (bank <= LAST_BANK));                            // R9
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (wptr[AW-1:PW] == $past(wptr[AW-1:PW])));                    // R5
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (state == ST_IDLE));                                         // R11

endmodule

// File: rtl/eeprom_bank_slave.sv
// Module: eeprom_bank_slave
// Top of the banked I2C serial memory target: line synchronizer, protocol
// engine, bank storage and write busy timer.
// Assumes: NUM_BANKS <= 4, WORDS and PAGE_BYTES powers of two, WORDS <= 256.
module eeprom_bank_slave #(
    parameter int NUM_BANKS   = 3,
    parameter int WORDS       = 256,
    parameter int PAGE_BYTES  = 8,
    parameter int BUSY_CYCLES = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);

    localparam int AW = $clog2(WORDS);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          busy, wr_done, mem_we;
    logic [1:0]    mem_bank;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [7:0]    mem_wdata, rdata;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_proto_fsm #(
        .NUM_BANKS  (NUM_BANKS),
        .WORDS      (WORDS),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .wp_i      (wp_i),
        .busy_i    (busy),
        .rdata     (rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_bank  (mem_bank),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .wr_done   (wr_done)
    );

    bank_store #(
        .NUM_BANKS (NUM_BANKS),
        .WORDS     (WORDS)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .wbank (mem_bank),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .rbank (mem_bank),
        .raddr (mem_raddr),
        .rdata (rdata)
    );

    write_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_done),
        .busy  (busy)
    );

    AST_WP_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wp_i);                                                      // R10

endmodule

// File: tb/eeprom_bank_slave_bench.sv
// Directed bench: an I2C controller model drives the bus through tasks and
// each scenario task checks its own read-back and acknowledge results.
module eeprom_bank_slave_bench;

    localparam int BUSY = 300;
    localparam int Q    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_low = 1'b0;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #5 clk = ~clk;
    assign sda_bus = ~(sda_low | sda_oe);

    eeprom_bank_slave #(.BUSY_CYCLES(BUSY)) u_eeprom_bank_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_low = 1'b0; tick(Q);
        scl_m = 1'b1;   tick(Q);
        sda_low = 1'b1; tick(Q);
        scl_m = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_low = 1'b1; tick(Q);
        scl_m = 1'b1;   tick(Q);
        sda_low = 1'b0; tick(Q);
    endtask

    task automatic wbit(input bit b);
        sda_low = ~b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbit(output bit b);
        sda_low = 1'b0; tick(Q);
        scl_m = 1'b1;   tick(Q);
        b = sda_bus;    tick(Q);
        scl_m = 1'b0;   tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(~ack);
    endtask

    function automatic logic [7:0] dev(input int bank, input bit rd);
        return {5'b10100, 2'(bank), rd};
    endfunction

    // Write n bytes from wbuf; reports header acks and data acks separately
    task automatic write_seq(input int bank, input int addr, input int n,
                             output bit hdr_ok, output bit dat_ok);
        bit a1, a2, a;
        bus_start();
        send_byte(dev(bank, 1'b0), a1);
        send_byte(8'(addr), a2);
        hdr_ok = a1 & a2;
        dat_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            dat_ok &= a;
        end
        bus_stop();
    endtask

    task automatic read_rand(input int bank, input int addr, input int n,
                             output bit ok);
        bit a1, a2, a3;
        bus_start();
        send_byte(dev(bank, 1'b0), a1);
        send_byte(8'(addr), a2);
        bus_start();
        send_byte(dev(bank, 1'b1), a3);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        bus_stop();
        ok = a1 & a2 & a3;
    endtask

    task automatic read_cur(input int bank, input int n, output bit ok);
        bus_start();
        send_byte(dev(bank, 1'b1), ok);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic write_one(input int bank, input int addr, input logic [7:0] d);
        bit h, k;
        wbuf[0] = d;
        write_seq(bank, addr, 1, h, k);
        chk("R3 write acks", int'(h & k), 1);
        tick(BUSY + 20);
    endtask

    task automatic t_reset();
        bit ok;
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        read_rand(0, 8'h10, 4, ok);
        chk("R1 header ack", int'(ok), 1);
        for (int i = 0; i < 4; i++) chk("R1 bank0 erased", int'(rbuf[i]), 8'hFF);
        read_rand(2, 8'hFE, 4, ok);
        for (int i = 0; i < 4; i++) chk("R1 bank2 erased", int'(rbuf[i]), 8'hFF);
    endtask

    task automatic t_address();
        bit a;
        bus_start(); send_byte(8'b1010_0110, a); bus_stop();
        chk("R2 bank3 not acked", int'(a), 0);
        bus_start(); send_byte(8'b1011_0000, a); bus_stop();
        chk("R2 wrong id not acked", int'(a), 0);
        bus_start(); send_byte(8'b1010_1000, a); bus_stop();
        chk("R2 bit3 set not acked", int'(a), 0);
        bus_start(); send_byte(dev(1, 1'b0), a); bus_stop();
        chk("R2 bank1 acked", int'(a), 1);
    endtask

    task automatic t_byte_write();
        bit ok;
        write_one(0, 8'h20, 8'h5A);
        read_rand(0, 8'h20, 1, ok);
        chk("R3 byte read back", int'(rbuf[0]), 8'h5A);
    endtask

    task automatic t_page();
        bit h, k, ok;
        for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h80 + i);
        write_seq(1, 8'h30, 8, h, k);
        chk("R4 page acks", int'(h & k), 1);
        tick(BUSY + 20);
        read_rand(1, 8'h30, 8, ok);
        for (int i = 0; i < 8; i++) chk("R4 page data", int'(rbuf[i]), 8'h80 + i);
        read_rand(0, 8'h30, 1, ok);
        chk("R9 bank0 untouched by bank1 write", int'(rbuf[0]), 8'hFF);
        read_rand(2, 8'h30, 1, ok);
        chk("R9 bank2 untouched by bank1 write", int'(rbuf[0]), 8'hFF);
    endtask

    task automatic t_page_wrap();
        bit h, k, ok;
        logic [7:0] exp [8];
        for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'hD0 + i);
        write_seq(2, 8'h45, 10, h, k);
        chk("R5 wrap acks", int'(h & k), 1);
        tick(BUSY + 20);
        // locations 45,46,47,40..46 in order: later bytes win
        exp = '{8'hD3, 8'hD4, 8'hD5, 8'hD6, 8'hD7, 8'hD8, 8'hD9, 8'hD2};
        read_rand(2, 8'h40, 9, ok);
        for (int i = 0; i < 8; i++) chk("R5 page wrap data", int'(rbuf[i]), int'(exp[i]));
        chk("R5 next page untouched", int'(rbuf[8]), 8'hFF);
    endtask

    task automatic t_seq_rollover();
        bit ok;
        write_one(0, 8'hFF, 8'hA1);
        write_one(0, 8'h00, 8'hA2);
        read_rand(0, 8'hFE, 3, ok);
        chk("R6 seq before top", int'(rbuf[0]), 8'hFF);
        chk("R6 seq top", int'(rbuf[1]), 8'hA1);
        chk("R6 rollover to 0 same bank", int'(rbuf[2]), 8'hA2);
        read_rand(1, 8'h00, 1, ok);
        chk("R9 bank1 addr0 untouched", int'(rbuf[0]), 8'hFF);
    endtask

    task automatic t_cur_after_read();
        bit ok;
        write_one(0, 8'h21, 8'h66);
        read_rand(0, 8'h20, 1, ok);
        chk("R7 random read", int'(rbuf[0]), 8'h5A);
        read_cur(0, 1, ok);
        chk("R7 current read ack", int'(ok), 1);
        chk("R7 current after read", int'(rbuf[0]), 8'h66);
        read_cur(0, 1, ok);
        chk("R7 current after current", int'(rbuf[0]), 8'hFF);
    endtask

    task automatic t_cur_after_write();
        bit h, k, ok;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        write_seq(1, 8'h40, 2, h, k);
        tick(BUSY + 20);
        read_cur(1, 1, ok);
        chk("R8 current after write", int'(rbuf[0]), 8'h22);
    endtask

    task automatic t_wp();
        bit h, k, ok;
        wp = 1'b1;
        wbuf[0] = 8'h33;
        write_seq(2, 8'h90, 1, h, k);
        chk("R10 header acked under wp", int'(h), 1);
        chk("R10 data not acked under wp", int'(k), 0);
        read_rand(2, 8'h90, 1, ok);
        chk("R10 no busy window under wp", int'(ok), 1);
        chk("R10 memory unchanged", int'(rbuf[0]), 8'hFF);
        wp = 1'b0;
    endtask

    task automatic t_busy();
        bit h, k, a, ok;
        wbuf[0] = 8'h77;
        write_seq(0, 8'h50, 1, h, k);
        bus_start(); send_byte(dev(0, 1'b0), a); bus_stop();
        chk("R11 address ignored while busy", int'(a), 0);
        tick(BUSY + 20);
        bus_start(); send_byte(dev(0, 1'b0), a); bus_stop();
        chk("R11 address acked after window", int'(a), 1);
        read_rand(0, 8'h50, 1, ok);
        chk("R11 write landed", int'(rbuf[0]), 8'h77);
    endtask

    task automatic t_nack_release();
        bit a1, a2, a3, b;
        logic [7:0] d;
        bus_start();
        send_byte(dev(0, 1'b0), a1);
        send_byte(8'h20, a2);
        bus_start();
        send_byte(dev(0, 1'b1), a3);
        recv_byte(1'b0, d);
        chk("R12 byte before nack", int'(d), 8'h5A);
        // next location holds 66h (bit7 = 0): a driving target would pull low
        rbit(b);
        chk("R12 sda released after nack", int'(b), 1);
        chk("R12 sda_oe low after nack", int'(sda_oe), 0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_address();
        t_byte_write();
        t_page();
        t_page_wrap();
        t_seq_rollover();
        t_cur_after_read();
        t_cur_after_write();
        t_wp();
        t_busy();
        t_nack_release();
        tick(10);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule